// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Non-Overlap and Short-Circuit Lockout

This block turns a direction bit and a PWM bit from a controller into four gate-enable outputs for a full bridge made of two legs. Leg 1 is the gate pair `gate_h1`/`gate_l1` and leg 2 is the pair `gate_h2`/`gate_l2`. In each direction one high-side gate stays on and its leg partner stays off. The other leg switches between its low-side gate, which follows PWM, and its high-side gate, which follows inverted PWM. The two direction and PWM inputs pass through two-flip-flop synchronisers before they are used.

Any change of the synchronised direction or PWM bit starts a non-overlap counter. Gates turn off at once. A gate may turn on only once that counter has run out, so the two gates of a leg are never on together. Each gate has its own blanking counter, which starts when the gate turns on. A desaturation report for a gate that is on is ignored until that gate's blanking window has passed. A report after the window latches a short-circuit lockout that forces all four gates off. The lockout is released only by the next PWM transition. A supply-undervoltage report forces the gates off at once, with no blanking, and releases itself when the report goes away. A global enable, derived elsewhere from supervisor and watchdog status, gates everything. The dead-time and blanking lengths are taken from configuration inputs only while the enable is low.

Top module: `hbridge_gate_seq`

## Requirements
- R1: One clock edge after `en` is sampled low, all four gate outputs are 0, whatever the values of `dir_in` and `pwm_in`.
- R2: With `dir_in`=0 and the inputs held steady, the outputs settle to `gate_h1`=1, `gate_l1`=0, `gate_l2`=PWM and `gate_h2`=NOT PWM.
- R3: With `dir_in`=1 and the inputs held steady, the outputs settle to `gate_h2`=1, `gate_l2`=0, `gate_l1`=PWM and `gate_h1`=NOT PWM.
- R4: `gate_h1` and `gate_l1` are never both 1, and `gate_h2` and `gate_l2` are never both 1.
- R5: Turn-off is not delayed. A gate whose target drops after a change of `pwm_in` is 0 three clock edges after the change: two synchroniser stages plus the output register. The gate that turns on rises exactly D+1 clock edges after its leg partner fell, where D is the loaded dead-time value.
- R6: With PWM held high continuously, the selected pair of gates (`gate_h1`+`gate_l2` for `dir_in`=0) stays on indefinitely.
- R7: `desat` bits map as bit0=H1, bit1=H2, bit2=L1, bit3=L2. A report in the first B cycles after the corresponding gate rises is ignored, where B is the loaded blanking value. If the report is held, `sc_flag` rises B+1 clock edges after the gate rose, and all gates are 0 on that same edge.
- R8: `sc_flag` and the all-off lockout set by a desaturation trip stay in force through direction changes. They clear only after the next transition of the synchronised PWM, and the gates then follow R2/R3 again.
- R9: One clock edge after `pbat_uv` is sampled high, `sc_flag`=1 and all gates are 0, with no blanking. One edge after it is sampled low, `sc_flag` returns to 0, and the gates resume with no PWM transition needed.
- R10: `cfg_dead` and `cfg_blank` are captured only while `en` is low. A change of either one while enabled has no effect on timing.
- R11: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global bridge enable |
| dir_in | input | 1 | Motor direction, asynchronous |
| pwm_in | input | 1 | PWM command, asynchronous |
| cfg_dead | input | CW | Non-overlap length in clock cycles |
| cfg_blank | input | CW | Short-circuit blanking length in clock cycles |
| desat | input | 4 | Desaturation reports: bit0 H1, bit1 H2, bit2 L1, bit3 L2 |
| pbat_uv | input | 1 | Bridge supply undervoltage report |
| gate_h1 | output | 1 | High-side gate, leg 1 |
| gate_h2 | output | 1 | High-side gate, leg 2 |
| gate_l1 | output | 1 | Low-side gate, leg 1 |
| gate_l2 | output | 1 | Low-side gate, leg 2 |
| sc_flag | output | 1 | Short-circuit or supply-fault indication |

## Verification
A non-overlap counter that is loaded wrongly or decrements wrongly shows up within one switching event as an off-to-on gap different from D+1 edges. In the worst case it shows as both gates of a leg high in the same cycle. A wrong blanking counter moves the rise of `sc_flag` away from B+1 edges after the gate rose, or lets a short pulse inside the window trip the bridge. A lockout latch that clears on the wrong event becomes visible as gates coming back after a direction change or with no edge at all, or as gates staying dark after a PWM transition or after the undervoltage has cleared.

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dir_in,
  input  logic          pwm_in,
  input  logic [CW-1:0] cfg_dead,
  input  logic [CW-1:0] cfg_blank,
  input  logic [3:0]    desat,
  input  logic          pbat_uv,
  output logic          gate_h1,
  output logic          gate_h2,
  output logic          gate_l1,
  output logic          gate_l2,
  output logic          sc_flag
);
  localparam int NG = 4;

  logic [1:0]    dsync, psync;
  logic          d_q, p_q;
  logic          dir_s, pwm_s, pedge, chg;
  logic [CW-1:0] dead_r, blank_r, dcnt;
  logic [NG-1:0] gate, tgt, gate_nxt, armed;
  logic          ready, trip, hold, sc_lat, uv_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dsync <= '0;
      psync <= '0;
      d_q   <= 1'b0;
      p_q   <= 1'b0;
    end else begin
      dsync <= {dsync[0], dir_in};
      psync <= {psync[0], pwm_in};
      d_q   <= dsync[1];
      p_q   <= psync[1];
    end

  assign dir_s = dsync[1];
  assign pwm_s = psync[1];
  assign pedge = pwm_s ^ p_q;
  assign chg   = pedge | (dir_s ^ d_q);

  // index: 0 H1, 1 H2, 2 L1, 3 L2
  assign tgt = dir_s ? {1'b0, pwm_s, 1'b1, ~pwm_s}
                     : {pwm_s, 1'b0, ~pwm_s, 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dead_r  <= '0;
      blank_r <= '0;
    end else if (!en) begin
      dead_r  <= cfg_dead;
      blank_r <= cfg_blank;
    end

  assign trip  = |(armed & desat);
  assign hold  = !en | pbat_uv | sc_lat | trip;
  assign ready = (dcnt == '0) && !chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      dcnt <= '0;
    else if (hold || chg)
      dcnt <= dead_r;
    else if (dcnt != '0)
      dcnt <= dcnt - 1'b1;

  assign gate_nxt = hold ? '0 : (tgt & (gate | {NG{ready}}));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gate <= '0;
    else        gate <= gate_nxt;

  for (genvar i = 0; i < NG; i++) begin : g_blank
    logic [CW-1:0] bcnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        bcnt <= '0;
      else if (!gate[i])
        bcnt <= blank_r;
      else if (bcnt != '0)
        bcnt <= bcnt - 1'b1;
    assign armed[i] = gate[i] && (bcnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sc_lat <= 1'b0;
      uv_q   <= 1'b0;
    end else begin
      uv_q <= pbat_uv;
      if (!en)
        sc_lat <= 1'b0;
      else if (trip)
        sc_lat <= 1'b1;
      else if (pedge)
        sc_lat <= 1'b0;
    end

  assign gate_h1 = gate[0];
  assign gate_h2 = gate[1];
  assign gate_l1 = gate[2];
  assign gate_l2 = gate[3];
  assign sc_flag = sc_lat | uv_q;
endmodule

// File: rtl/hbridge_gate_seq_chk.sv
module hbridge_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic pbat_uv,
  input logic gate_h1,
  input logic gate_h2,
  input logic gate_l1,
  input logic gate_l2,
  input logic sc_flag,
  input logic sc_lat,
  input logic pedge
);
  logic any_on;
  assign any_on = gate_h1 | gate_h2 | gate_l1 | gate_l2;

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !any_on); // R1
  AST_LEG1_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(gate_h1 && gate_l1)); // R4
  AST_LEG2_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(gate_h2 && gate_l2)); // R4
  AST_H1_AFTER_L1: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_h1) |-> !$past(gate_l1)); // R5
  AST_L2_AFTER_H2: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_l2) |-> !$past(gate_h2)); // R5
  AST_FLAG_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n) sc_flag |-> !any_on); // R7
  AST_REARM_PWM: assert property (@(posedge clk) disable iff (!rst_n) $fell(sc_lat) |-> ($past(pedge) || !$past(en))); // R8
  AST_UV_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n) pbat_uv |=> (sc_flag && !any_on)); // R9
endmodule

bind hbridge_gate_seq hbridge_gate_seq_chk chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pbat_uv(pbat_uv),
  .gate_h1(gate_h1), .gate_h2(gate_h2), .gate_l1(gate_l1), .gate_l2(gate_l2),
  .sc_flag(sc_flag), .sc_lat(sc_lat), .pedge(pedge)
);

// File: tb/hbridge_gate_seq_test.sv
module hbridge_gate_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int DEAD = 4;
  localparam int BLANK = 6;

  logic clk = 1'b0;
  logic rst_n, en, dir_in, pwm_in, pbat_uv;
  logic [CW-1:0] cfg_dead, cfg_blank;
  logic [3:0] desat;
  logic gate_h1, gate_h2, gate_l1, gate_l2, sc_flag;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_gate_seq #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .dir_in(dir_in), .pwm_in(pwm_in),
    .cfg_dead(cfg_dead), .cfg_blank(cfg_blank), .desat(desat), .pbat_uv(pbat_uv),
    .gate_h1(gate_h1), .gate_h2(gate_h2), .gate_l1(gate_l1), .gate_l2(gate_l2),
    .sc_flag(sc_flag)
  );

  function automatic logic [3:0] gates();
    return {gate_l2, gate_l1, gate_h2, gate_h1};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] expect_map(input logic d, input logic p);
    return d ? {1'b0, p, 1'b1, ~p} : {p, 1'b0, ~p, 1'b1};
  endfunction

  task automatic gap(input int off_i, input int on_i, output int g);
    int n = 0;
    while (gates()[off_i] && n < 200) begin cyc(1); n++; end
    g = 0;
    while (!gates()[on_i] && g < 200) begin
      cyc(1); g++;
      chk(!((gate_h1 && gate_l1) || (gate_h2 && gate_l2)), "R4", gates(), 0);
    end
  endtask

  task automatic t_reset();
    cyc(3);
    chk(gates() == 4'b0 && !sc_flag, "R11", {sc_flag, gates()}, 0);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_forward();
    en = 1'b1; dir_in = 1'b0; pwm_in = 1'b0;
    cyc(20);
    chk(gates() == expect_map(0, 0), "R2", gates(), expect_map(0, 0));
    pwm_in = 1'b1;
    cyc(20);
    chk(gates() == expect_map(0, 1), "R2", gates(), expect_map(0, 1));
  endtask

  task automatic t_deadtime();
    int g;
    pwm_in = 1'b0;
    cyc(2);
    chk(gate_l2 == 1'b1, "R5", gate_l2, 1);
    cyc(1);
    chk(gate_l2 == 1'b0, "R5", gate_l2, 0);
    gap(3, 1, g);
    chk(g == DEAD + 1, "R5", g, DEAD + 1);
    cyc(10);
    pwm_in = 1'b1;
    gap(1, 3, g);
    chk(g == DEAD + 1, "R5", g, DEAD + 1);
    cyc(10);
  endtask

  task automatic t_reverse();
    dir_in = 1'b1; pwm_in = 1'b1;
    cyc(20);
    chk(gates() == expect_map(1, 1), "R3", gates(), expect_map(1, 1));
    pwm_in = 1'b0;
    cyc(20);
    chk(gates() == expect_map(1, 0), "R3", gates(), expect_map(1, 0));
  endtask

  task automatic t_full_duty();
    int bad = 0;
    dir_in = 1'b0; pwm_in = 1'b1;
    cyc(20);
    for (int i = 0; i < 500; i++) begin
      if (!(gate_h1 && gate_l2 && !gate_h2 && !gate_l1)) bad++;
      cyc(1);
    end
    chk(bad == 0, "R6", bad, 0);
  endtask

  task automatic t_cfg_and_enable();
    int g;
    cfg_dead = 16'd20;
    pwm_in = 1'b0;
    gap(3, 1, g);
    chk(g == DEAD + 1, "R10", g, DEAD + 1);
    cyc(10);
    dir_in = 1'b1; pwm_in = 1'b1;
    en = 1'b0;
    cyc(1);
    chk(gates() == 4'b0, "R1", gates(), 0);
    cyc(30);
    chk(gates() == 4'b0, "R1", gates(), 0);
    dir_in = 1'b0; pwm_in = 1'b1;
    cyc(10);
    en = 1'b1;
    cyc(40);
    pwm_in = 1'b0;
    gap(3, 1, g);
    chk(g == 21, "R10", g, 21);
    en = 1'b0; cfg_dead = DEAD; cyc(5);
    en = 1'b1; cyc(40);
  endtask

  task automatic t_blanking();
    int n;
    int m;
    dir_in = 1'b0; pwm_in = 1'b0; cyc(20);
    pwm_in = 1'b1;
    n = 0;
    while (!gate_l2 && n < 200) begin cyc(1); n++; end
    desat = 4'b1000;
    cyc(BLANK);
    desat = 4'b0000;
    cyc(10);
    chk(!sc_flag && gate_l2, "R7", {sc_flag, gate_l2}, 1);
    pwm_in = 1'b0; cyc(20);
    desat = 4'b1000;
    pwm_in = 1'b1;
    n = 0;
    while (!gate_l2 && n < 200) begin cyc(1); n++; end
    m = 0;
    while (!sc_flag && m < 200) begin cyc(1); m++; end
    chk(m == BLANK + 1, "R7", m, BLANK + 1);
    chk(gates() == 4'b0, "R7", gates(), 0);
    desat = 4'b0000;
  endtask

  task automatic t_lockout();
    cyc(30);
    chk(sc_flag && gates() == 4'b0, "R8", {sc_flag, gates()}, 16);
    dir_in = 1'b1;
    cyc(30);
    chk(sc_flag && gates() == 4'b0, "R8", {sc_flag, gates()}, 16);
    pwm_in = 1'b0;
    cyc(20);
    chk(!sc_flag && gates() == expect_map(1, 0), "R8", {sc_flag, gates()}, expect_map(1, 0));
  endtask

  task automatic t_undervoltage();
    dir_in = 1'b0; pwm_in = 1'b1; cyc(20);
    pbat_uv = 1'b1;
    cyc(1);
    chk(sc_flag && gates() == 4'b0, "R9", {sc_flag, gates()}, 16);
    cyc(10);
    pbat_uv = 1'b0;
    cyc(1);
    chk(!sc_flag, "R9", sc_flag, 0);
    cyc(20);
    chk(gates() == expect_map(0, 1), "R9", gates(), expect_map(0, 1));
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; dir_in = 1'b0; pwm_in = 1'b0; pbat_uv = 1'b0;
    cfg_dead = DEAD; cfg_blank = BLANK; desat = 4'b0;
    t_reset();
    t_forward();
    t_deadtime();
    t_reverse();
    t_full_duty();
    t_cfg_and_enable();
    t_blanking();
    t_lockout();
    t_undervoltage();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule